// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It moves a programmed number of data items from one bus address to another. It is the only master on a simple bus. Each bus access is a request that the engine holds until the bus grants it. Every item is one read at the source width, followed by one write of the resized value at the destination width.

Two register sets describe the two ends of a transfer: a "port-side" set and a "memory-side" set. Each set has an address, a size field and an increment bit. A direction bit decides which set is the source and which is the destination. With this one engine, software can set up peripheral-to-memory, memory-to-peripheral, peripheral-to-peripheral and memory-to-memory moves.

The engine can run in two ways:
- **Paced:** each cycle of the external request line starts one item.
- **Free-running:** when the memory-to-memory bit is set, items run back to back with no request.

When the item count runs out, the engine raises a done flag and clears its own enable bit.

Top module: `xfer_channel`

## Requirements
- R1: While reset is applied and after it is released, `bus_req` and `xfer_done` are low until the channel is enabled.
- R2: The engine holds a raised `bus_req` with stable `bus_we`, `bus_addr`, `bus_size` and `bus_wdata` until it sees `bus_gnt`. Each item is one granted read (`bus_we`=0), then at once one write (`bus_we`=1), then one cycle with no request.
- R3: With the direction bit at 1, the source uses the memory-side address, size and increment, and the destination uses the port-side set. With the direction bit at 0, the two roles swap.
- R4: Size codes are: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, and 11 (reserved) = 4 bytes. After each item, an address whose increment bit is set advances by its own item size. An address whose increment bit is clear stays fixed.
- R5: Items sit right-justified on `bus_rdata` and `bus_wdata`. A wider source is cut down to its low destination-size bytes. A narrower source is zero-extended.
- R6: When the memory-to-memory bit is clear, one item starts for each cycle in which `periph_req` is high. No item starts without a request.
- R7: A request that arrives while an item is in progress is kept and serviced after that item ends.
- R8: When the memory-to-memory bit is set, items run with no request until the count is used up.
- R9: The count drops by one on each granted write. When it reaches zero, `xfer_done` goes high, the enable bit clears, and requests are ignored. Writing the enable bit as 1 clears `xfer_done`.
- R10: While the channel is enabled or an item is in progress, writes to the addresses, the count and the control fields other than enable have no effect.
- R11: Clearing the enable bit during an item lets that item finish its write. No further item starts, and `xfer_done` stays low.
- R12: A configuration write is taken at a clock edge when `cfg_we` is high. `cfg_sel` picks the target:
  - 0 = control, with bit 0 enable, bit 1 direction, bit 2 memory-to-memory, bits 4:3 port-side size, bits 6:5 memory-side size, bit 7 port-side increment and bit 8 memory-side increment;
  - 1 = port-side address;
  - 2 = memory-side address;
  - 3 = item count in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| periph_req | input | 1 | Pacing request, one item per high cycle |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Size code of the access |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_gnt | input | 1 | Grant; completes the access in this cycle |
| bus_rdata | input | 32 | Read data, valid in the granted read cycle |
| xfer_done | output | 1 | Transfer-complete flag |

## Verification
The bench runs transfers with a 4-byte source into a 1-byte destination and a 1-byte source into a 4-byte destination. These two cases tell truncation apart from zero extension. It also runs 2-byte to 2-byte and reserved-size to 4-byte transfers, which confirm the address step for each size code. Both directions are used, each with a fixed end and an incrementing end, so a swapped register set shows up as a wrong address or a wrong step. Paced runs with no request, single requests, and a request that arrives while a stalled item is in progress separate the pacing logic from the free-running mode. Writes made while the channel is enabled, and an enable drop during a stalled read, confirm the locking and the abort at an item boundary.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_state_e;

  // Control word, bit 0 is enable, bit 8 is memory-side increment.
  typedef struct packed {
    logic       minc;
    logic       pinc;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       m2m;
    logic       dir;
    logic       en;
  } xfer_ctrl_t;

  localparam int CTRL_W = $bits(xfer_ctrl_t);

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PADDR = 2'd1;
  localparam logic [1:0] SEL_MADDR = 2'd2;
  localparam logic [1:0] SEL_COUNT = 2'd3;

  // Bytes per item for a size code; reserved code behaves as a word.
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   size_bytes = 3'd1;
      2'b01:   size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/xfer_resize.sv
module xfer_resize
  import xfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    src_sz,
  input  logic [1:0]    dst_sz,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  localparam int NB = DW / 8;

  logic [2:0] src_b;
  logic [2:0] dst_b;
  logic [2:0] keep_b;

  assign src_b  = size_bytes(src_sz);
  assign dst_b  = size_bytes(dst_sz);
  assign keep_b = (src_b < dst_b) ? src_b : dst_b;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign dout[8*g +: 8] = (keep_b > 3'(g)) ? din[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
  import xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    sz,
  input  logic          inc,
  output logic [AW-1:0] addr_next
);

  logic [AW-1:0] step;

  assign step      = inc ? AW'(size_bytes(sz)) : '0;
  assign addr_next = addr + step;

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
  import xfer_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          periph_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_done
);

  logic srst_n;

  xfer_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  xfer_state_e   state_q, state_d;
  xfer_ctrl_t    ctrl_q, ctrl_d;
  logic [AW-1:0] paddr_q, paddr_d, maddr_q, maddr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          done_q, done_d;
  logic [DW-1:0] data_q;

  // Role selection by direction
  logic [AW-1:0] src_addr, dst_addr;
  logic [1:0]    src_sz, dst_sz;

  assign src_addr = ctrl_q.dir ? maddr_q      : paddr_q;
  assign dst_addr = ctrl_q.dir ? paddr_q      : maddr_q;
  assign src_sz   = ctrl_q.dir ? ctrl_q.msize : ctrl_q.psize;
  assign dst_sz   = ctrl_q.dir ? ctrl_q.psize : ctrl_q.msize;

  logic [DW-1:0] rd_fit;

  xfer_resize #(.DW(DW)) u_resize (
    .src_sz (src_sz),
    .dst_sz (dst_sz),
    .din    (bus_rdata),
    .dout   (rd_fit)
  );

  logic [AW-1:0] paddr_adv, maddr_adv;

  xfer_addr_step #(.AW(AW)) u_pstep (
    .addr      (paddr_q),
    .sz        (ctrl_q.psize),
    .inc       (ctrl_q.pinc),
    .addr_next (paddr_adv)
  );

  xfer_addr_step #(.AW(AW)) u_mstep (
    .addr      (maddr_q),
    .sz        (ctrl_q.msize),
    .inc       (ctrl_q.minc),
    .addr_next (maddr_adv)
  );

  logic start, rd_fire, wr_fire, locked;

  assign locked  = ctrl_q.en || (state_q != ST_IDLE);
  assign start   = (state_q == ST_IDLE) && ctrl_q.en && (cnt_q != '0) &&
                   (ctrl_q.m2m || pend_q);
  assign rd_fire = (state_q == ST_RD) && bus_gnt;
  assign wr_fire = (state_q == ST_WR) && bus_gnt;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    paddr_d = paddr_q;
    maddr_d = maddr_q;
    cnt_d   = cnt_q;
    done_d  = done_q;

    if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: begin
          if (locked) ctrl_d.en = cfg_wdata[0];
          else        ctrl_d    = xfer_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          if (cfg_wdata[0]) done_d = 1'b0;
        end
        SEL_PADDR: if (!locked) paddr_d = cfg_wdata;
        SEL_MADDR: if (!locked) maddr_d = cfg_wdata;
        default:   if (!locked) cnt_d   = cfg_wdata[CW-1:0];
      endcase
    end

    case (state_q)
      ST_IDLE: if (start) state_d = ST_RD;
      ST_RD:   if (rd_fire) state_d = ST_WR;
      ST_WR: begin
        if (wr_fire) begin
          state_d = ST_IDLE;
          cnt_d   = cnt_q - 1'b1;
          paddr_d = paddr_adv;
          maddr_d = maddr_adv;
          if (cnt_q == CW'(1)) begin
            done_d    = 1'b1;
            ctrl_d.en = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (!ctrl_q.en || ctrl_q.m2m) pend_d = 1'b0;
    else                          pend_d = (pend_q && !start) || periph_req;
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      paddr_q <= '0;
      maddr_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      paddr_q <= paddr_d;
      maddr_q <= maddr_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  // Item data buffer, loaded on a granted read
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      data_q <= '0;
    else if (rd_fire) data_q <= rd_fit;
  end

  assign bus_req   = (state_q != ST_IDLE);
  assign bus_we    = (state_q == ST_WR);
  assign bus_addr  = bus_we ? dst_addr : src_addr;
  assign bus_size  = bus_we ? dst_sz   : src_sz;
  assign bus_wdata = data_q;
  assign xfer_done = done_q;

endmodule

// File: rtl/xfer_channel_chk.sv
module xfer_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_wdata,
  input logic        bus_gnt,
  input logic        xfer_done
);

  AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) &&
                               $stable(bus_size) && $stable(bus_wdata))); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_gnt) |=> (bus_req && bus_we)); // R2

  AST_WRITE_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_gnt) |=> !bus_req); // R2

  AST_WDATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> ((bus_size == 2'b00) ? (bus_wdata[31:8] == 24'h0) :
                             (bus_size == 2'b01) ? (bus_wdata[31:16] == 16'h0) : 1'b1)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !bus_req); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $past(bus_req && bus_we && bus_gnt)); // R9

endmodule

bind xfer_channel xfer_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_gnt   (bus_gnt),
  .xfer_done (xfer_done)
);

// File: tb/xfer_channel_bench.sv
module xfer_channel_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        periph_req;
  logic        bus_req, bus_we, bus_gnt, xfer_done;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        gnt_en;

  always #2 clk = ~clk;

  xfer_channel u_xfer_channel (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .periph_req (periph_req),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_gnt    (bus_gnt),
    .bus_rdata  (bus_rdata),
    .xfer_done  (xfer_done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    pat = {a[7:0] ^ 8'hC3, a[7:0] + 8'h51, ~a[7:0], a[7:0] + 8'h01};
  endfunction

  assign bus_gnt   = bus_req && gnt_en;
  assign bus_rdata = pat(bus_addr);

  // Bus log
  logic [31:0] wr_addr [32];
  logic [31:0] wr_data [32];
  logic [1:0]  wr_size [32];
  logic [31:0] rd_addr [32];
  int wr_n = 0;
  int rd_n = 0;

  always @(negedge clk) begin
    if (bus_req && bus_gnt) begin
      if (bus_we) begin
        if (wr_n < 32) begin
          wr_addr[wr_n] = bus_addr;
          wr_data[wr_n] = bus_wdata;
          wr_size[wr_n] = bus_size;
        end
        wr_n++;
      end else begin
        if (rd_n < 32) rd_addr[rd_n] = bus_addr;
        rd_n++;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit dir, input bit m2m,
                                       input logic [1:0] psz, input logic [1:0] msz,
                                       input bit pinc, input bit minc);
    ctrl = {23'h0, minc, pinc, msz, psz, m2m, dir, en};
  endfunction

  task automatic clear_log();
    @(negedge clk);
    wr_n = 0; rd_n = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    periph_req = 1'b0; gnt_en = 1'b1;
    idle(4);
    chk_eq("R1", "req in reset", 32'(bus_req), 0);
    chk_eq("R1", "done in reset", 32'(xfer_done), 0);
    rst_n = 1'b1;
    idle(6);
    chk_eq("R1", "req after reset", 32'(bus_req), 0);
    chk_eq("R1", "done after reset", 32'(xfer_done), 0);
  endtask

  // Free-running, dir=1: word source, byte destination, both increment
  task automatic t_m2m_truncate();
    clear_log();
    cfg_write(2'd1, 32'h100);
    cfg_write(2'd2, 32'h200);
    cfg_write(2'd3, 32'd3);
    cfg_write(2'd0, ctrl(1, 1, 1, 2'b00, 2'b10, 1, 1));
    idle(40);
    chk_eq("R8", "items without request", wr_n, 3);
    chk_eq("R9", "done after count", 32'(xfer_done), 1);
    for (int i = 0; i < 3; i++) begin
      chk_eq("R3", "src from memory-side", rd_addr[i], 32'h200 + 4*i);
      chk_eq("R4", "byte dst step", wr_addr[i], 32'h100 + i);
      chk_eq("R5", "truncated data", wr_data[i], pat(32'h200 + 4*i) & 32'hFF);
      chk_eq("R5", "dst size", 32'(wr_size[i]), 0);
    end
  endtask

  // Paced, dir=0: fixed byte source, word destination
  task automatic t_paced_extend();
    clear_log();
    cfg_write(2'd1, 32'h40);
    cfg_write(2'd2, 32'h300);
    cfg_write(2'd3, 32'd2);
    cfg_write(2'd0, ctrl(1, 0, 0, 2'b00, 2'b10, 0, 1));
    chk_eq("R9", "done cleared by enable", 32'(xfer_done), 0);
    idle(20);
    chk_eq("R6", "no item without request", wr_n, 0);
    pulse_req(); idle(10);
    chk_eq("R6", "one item per request", wr_n, 1);
    pulse_req(); idle(10);
    chk_eq("R6", "second item", wr_n, 2);
    chk_eq("R3", "src port-side fixed 0", rd_addr[0], 32'h40);
    chk_eq("R4", "src port-side fixed 1", rd_addr[1], 32'h40);
    chk_eq("R4", "word dst step", wr_addr[1], 32'h304);
    chk_eq("R5", "zero-extended data", wr_data[0], pat(32'h40) & 32'hFF);
    chk_eq("R9", "done", 32'(xfer_done), 1);
    pulse_req(); idle(3); pulse_req(); idle(10);
    chk_eq("R9", "requests ignored when done", wr_n, 2);
  endtask

  // Request arriving during a stalled item
  task automatic t_held_request();
    clear_log();
    cfg_write(2'd1, 32'h600);
    cfg_write(2'd2, 32'h500);
    cfg_write(2'd3, 32'd2);
    gnt_en = 1'b0;
    cfg_write(2'd0, ctrl(1, 1, 0, 2'b01, 2'b01, 1, 1));
    pulse_req(); idle(2);
    pulse_req(); idle(5);
    chk_eq("R2", "no access before grant", wr_n, 0);
    chk_eq("R2", "request held while stalled", 32'(bus_req), 1);
    gnt_en = 1'b1;
    idle(20);
    chk_eq("R7", "held request serviced", wr_n, 2);
    chk_eq("R4", "half dst step", wr_addr[1], 32'h602);
    chk_eq("R4", "half src step", rd_addr[1], 32'h502);
    chk_eq("R5", "half data", wr_data[1], pat(32'h502) & 32'hFFFF);
    chk_eq("R9", "done", 32'(xfer_done), 1);
  endtask

  // Writes while enabled are ignored; reserved size acts as a word
  task automatic t_lock();
    clear_log();
    cfg_write(2'd1, 32'h700);
    cfg_write(2'd2, 32'h800);
    cfg_write(2'd3, 32'd5);
    cfg_write(2'd0, ctrl(1, 0, 0, 2'b11, 2'b10, 1, 1));
    cfg_write(2'd3, 32'd1);
    cfg_write(2'd1, 32'h999);
    cfg_write(2'd0, ctrl(1, 1, 1, 2'b00, 2'b00, 0, 0));
    idle(10);
    chk_eq("R10", "mode bits locked", wr_n, 0);
    pulse_req(); idle(10);
    pulse_req(); idle(10);
    chk_eq("R10", "items", wr_n, 2);
    chk_eq("R10", "count locked", 32'(xfer_done), 0);
    chk_eq("R10", "port addr locked", rd_addr[0], 32'h700);
    chk_eq("R4", "reserved size step", rd_addr[1], 32'h704);
    chk_eq("R5", "reserved size full data", wr_data[1], pat(32'h704));
    chk_eq("R3", "dst memory-side", wr_addr[1], 32'h804);
    cfg_write(2'd0, 32'h0);
  endtask

  // Enable drop during a stalled read
  task automatic t_abort();
    clear_log();
    gnt_en = 1'b0;
    cfg_write(2'd0, ctrl(1, 0, 1, 2'b10, 2'b10, 1, 1));
    idle(3);
    cfg_write(2'd0, 32'h0);
    gnt_en = 1'b1;
    idle(20);
    chk_eq("R11", "item in flight finishes", wr_n, 1);
    chk_eq("R11", "abort item dst", wr_addr[0], 32'h808);
    chk_eq("R11", "abort item src", rd_addr[0], 32'h708);
    chk_eq("R11", "no done on abort", 32'(xfer_done), 0);
    chk_eq("R11", "bus quiet", 32'(bus_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_m2m_truncate();
    t_paced_extend();
    t_held_request();
    t_lock();
    t_abort();
    // R12: every scenario above programs the engine through cfg_sel 0..3
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule